// File: doc/BRIEF.md
# Calibration Trigger Sequencer

This block turns one slow control pin into two functions: powering the loop down and starting a loop-gain self-calibration. While the pin is high the powerdown output is high. When the pin falls after a long enough high period, the block treats the edge as a calibration trigger. It then issues a single-cycle calibrate request to the gain-setting logic and waits for that logic to answer with a done handshake.

A trigger counts only while the reference clock is reported valid. A trigger that arrives without a valid reference is held pending, and the request is issued as soon as the reference becomes valid. If the pin rises again while a calibration is pending or running, that calibration is abandoned and the loop goes back to powerdown. The busy and done outputs report the progress of the calibration.

The pin is asynchronous and is synchronised inside the block. The reference-valid flag and the done handshake are expected to be synchronous to the system clock. The minimum high time is given in nanoseconds. It is turned into a cycle count from a clock-frequency parameter, rounding up.

Top module: `cal_trig_seq`

## Requirements
- R1: `pwrdn_o` follows the pin through a synchroniser of `SYNC_STAGES` flops. With the default of 2, a pin change driven before rising edge k shows on `pwrdn_o` after rising edge k+1.
- R2: A falling edge is qualified only if the synchronised pin was high for at least MIN_CYC clock cycles, where MIN_CYC = ceil(CLK_HZ × MIN_HIGH_NS / 1e9), which is 100 at the defaults. With a shorter high period the falling edge starts nothing.
- R3: A qualified fall with `ref_valid_i` high drives `cal_req_o` high after the third rising edge following the pin fall.
- R4: `cal_req_o` is high for exactly one cycle per calibration.
- R5: `busy_o` goes high together with `cal_req_o` and stays high until `cal_done_i` is sampled high. After that edge `busy_o` is low and `done_o` is high.
- R6: A qualified fall while `ref_valid_i` is low issues no request. The request follows on the first rising edge at which `ref_valid_i` is sampled high.
- R7: A rising pin edge while busy ends the calibration. `busy_o` drops on the third rising edge after the pin rise, and `done_o` stays low.
- R8: A rising pin edge while a trigger is pending drops that trigger. A later `ref_valid_i` issues no request.
- R9: `done_o` is cleared by the next qualified fall or by reset. Unqualified falls, and `cal_done_i` while not busy, leave it unchanged.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_pin_i | input | 1 | Asynchronous powerdown/calibrate control pin |
| ref_valid_i | input | 1 | Reference clock present and valid |
| cal_done_i | input | 1 | Handshake from the gain-setting logic: calibration finished |
| pwrdn_o | output | 1 | Loop powerdown, high while the synchronised pin is high |
| cal_req_o | output | 1 | One-cycle calibrate request |
| busy_o | output | 1 | Calibration requested and not yet finished |
| done_o | output | 1 | Last calibration finished normally |

## Verification
The checks made on every cycle concern the handshake and its state:
- the request is a single-cycle pulse;
- the request is raised together with busy;
- the request needs the reference to have been valid;
- a done handshake ends busy and sets done;
- an abort ends busy without setting done.

Only the bench scenarios can show the behaviours that span many cycles or depend on the pin. These are:
- the exact high-time boundary at MIN_CYC against MIN_CYC−1;
- the synchroniser and request latencies;
- the pending trigger released by the reference becoming valid;
- a pending trigger dropped when the pin rises;
- done surviving unqualified edges.

// File: rtl/cts_pkg.sv
package cts_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_WAIT = 2'd2
   } cts_state_e;

   // Cycles needed to cover ns at clk_hz, rounded up, at least 1
   function automatic int unsigned min_cycles(input longint unsigned clk_hz,
                                              input longint unsigned ns);
      longint unsigned c;
      c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c < 1) c = 1;
      return int'(c);
   endfunction
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cts_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cts_high_qual.sv
module cts_high_qual #(
   parameter int unsigned MIN_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic fall_ok_o,
   output logic rise_o
);
   localparam int CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("cts_high_qual: MIN_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] hi_cnt;
   logic          lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         lvl_q  <= 1'b0;
      end else begin
         lvl_q <= lvl_i;
         if (!lvl_i)            hi_cnt <= '0;
         else if (hi_cnt < SAT) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign fall_ok_o = lvl_q && !lvl_i && (hi_cnt == SAT);
   assign rise_o    = !lvl_q && lvl_i;
endmodule

// File: rtl/cts_fsm.sv
module cts_fsm
   import cts_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic rise_i,
   input  logic ref_valid_i,
   input  logic cal_done_i,
   output logic cal_req_o,
   output logic busy_o,
   output logic done_o
);
   cts_state_e state;
   logic       req_q;
   logic       done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         req_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (trig_i) begin
               done_q <= 1'b0;
               if (ref_valid_i) begin
                  state <= ST_WAIT;
                  req_q <= 1'b1;
               end else begin
                  state <= ST_PEND;
               end
            end
            ST_PEND: if (rise_i) begin
               state <= ST_IDLE;
            end else if (ref_valid_i) begin
               state <= ST_WAIT;
               req_q <= 1'b1;
            end
            ST_WAIT: if (rise_i) begin
               state <= ST_IDLE;
            end else if (cal_done_i) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cal_req_o = req_q;
   assign busy_o    = (state == ST_WAIT);
   assign done_o    = done_q;

   // R4: request never lasts two cycles
   a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req_o |=> !cal_req_o);
   // R5: request comes with busy
   a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req_o |-> busy_o);
   // R5: done handshake closes busy and sets done
   a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cal_done_i && !rise_i) |=> (!busy_o && done_o));
   // R6: request only after reference seen valid
   a_r6_ref_needed: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req_o |-> $past(ref_valid_i));
   // R7: abort drops busy without done
   a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rise_i) |=> (!busy_o && !done_o));
   // R8: rise while pending leaves nothing requested
   a_r8_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PEND && rise_i) |=> (!cal_req_o && !busy_o));
   // R9: done only rises out of a busy calibration with handshake
   a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(busy_o) && $past(cal_done_i)));
endmodule

// File: rtl/cal_trig_seq.sv
module cal_trig_seq #(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned MIN_HIGH_NS = 1000,
   parameter int          SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_pin_i,
   input  logic ref_valid_i,
   input  logic cal_done_i,
   output logic pwrdn_o,
   output logic cal_req_o,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned MIN_CYC =
      cts_pkg::min_cycles(longint'(CLK_HZ), longint'(MIN_HIGH_NS));

   generate
      if (CLK_HZ == 0) begin : g_bad_clk
         $error("cal_trig_seq: CLK_HZ must be non-zero");
      end
   endgenerate

   logic pin_s;
   logic trig;
   logic rise;

   cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ctrl_pin_i),
      .q_o   (pin_s)
   );

   cts_high_qual #(.MIN_CYC(MIN_CYC)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (pin_s),
      .fall_ok_o (trig),
      .rise_o    (rise)
   );

   cts_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .rise_i      (rise),
      .ref_valid_i (ref_valid_i),
      .cal_done_i  (cal_done_i),
      .cal_req_o   (cal_req_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   assign pwrdn_o = pin_s;

   // R2: a trigger needs the loop to have been powered down just before
   a_r2_trig_after_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> ($past(pwrdn_o) && !pwrdn_o));
endmodule

// File: tb/tb_cal_trig_seq.sv
module tb_cal_trig_seq;
   localparam int MIN_HI = 100; // 1 us at 100 MHz

   logic clk = 1'b0;
   logic rst_n, pin, refv, cdone;
   logic pwrdn, req, busy, done;
   int   n_cmp = 0;
   int   n_bad = 0;
   logic exp_done;

   always #5 clk = ~clk;

   cal_trig_seq dut (
      .clk(clk), .rst_n(rst_n), .ctrl_pin_i(pin), .ref_valid_i(refv),
      .cal_done_i(cdone), .pwrdn_o(pwrdn), .cal_req_o(req),
      .busy_o(busy), .done_o(done)
   );

   function automatic bit qual(input int n);
      return n >= MIN_HI;
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_high(input int n);
      pin = 1'b1;
      repeat (n) step();
      pin = 1'b0;
   endtask

   task automatic count_req(input int n, output int c);
      c = 0;
      repeat (n) begin
         step();
         if (req) c++;
      end
   endtask

   task automatic finish_cal();
      cdone = 1'b1;
      step();
      cdone = 1'b0;
      chk("R5 busy after done", busy, 0);
      chk("R5 done after done", done, 1);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R5 watchdog actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      int c;
      void'($urandom(32'd2024));
      pin = 0; refv = 0; cdone = 0; rst_n = 0;
      repeat (3) step();
      chk("R10 reset outputs", int'({pwrdn, req, busy, done}), 0);
      rst_n = 1;
      step();

      // R1 latency and R2 exact boundary, R3 request timing
      pin = 1; step();
      chk("R1 pwrdn after one edge", pwrdn, 0);
      step();
      chk("R1 pwrdn after two edges", pwrdn, 1);
      repeat (MIN_HI - 2) step();
      refv = 1; pin = 0;
      step(); step();
      chk("R3 no early req", req, 0);
      step();
      chk("R3 req on third edge", req, 1);
      chk("R5 busy with req", busy, 1);
      step();
      chk("R4 req single cycle", req, 0);
      chk("R1 pwrdn low", pwrdn, 0);
      repeat (5) step();
      chk("R5 busy held", busy, 1);
      finish_cal();

      // R2 one cycle short
      pulse_high(MIN_HI - 1);
      count_req(8, c);
      chk("R2 short high ignored", c, 0);
      chk("R9 done kept on unqualified fall", done, 1);

      // R9 handshake while idle
      cdone = 1; step(); cdone = 0;
      chk("R9 done kept on idle handshake", done, 1);
      chk("R9 busy stays low", busy, 0);

      // R6 pending until reference valid
      refv = 0;
      pulse_high(MIN_HI + 20);
      count_req(10, c);
      chk("R6 no req without ref", c, 0);
      chk("R9 done cleared by trigger", done, 0);
      refv = 1; step();
      chk("R6 req after ref valid", req, 1);
      finish_cal();

      // R7 abort while busy
      pulse_high(150);
      step(); step(); step();
      chk("R7 req before abort", req, 1);
      pin = 1; step(); step();
      chk("R7 busy before abort lands", busy, 1);
      step();
      chk("R7 busy after abort", busy, 0);
      chk("R7 done after abort", done, 0);
      chk("R7 pwrdn after abort", pwrdn, 1);
      cdone = 1; step(); cdone = 0;
      chk("R9 late handshake ignored", done, 0);
      pin = 0;
      count_req(8, c);
      chk("R2 short high after abort", c, 0);

      // R8 pending dropped on rise
      refv = 0;
      pulse_high(120);
      repeat (5) step();
      pin = 1; repeat (4) step();
      refv = 1;
      count_req(10, c);
      chk("R8 pending dropped", c, 0);
      pin = 0;
      count_req(6, c);
      chk("R8 no req after short high", c, 0);
      exp_done = 0;

      // Random mix
      for (int i = 0; i < 40; i++) begin
         int n;
         bit r;
         if ($urandom % 2) n = MIN_HI - 5 + int'($urandom % 10);
         else              n = MIN_HI + int'($urandom % 150);
         r = 1'($urandom % 2);
         refv = r;
         pulse_high(n);
         count_req(6, c);
         if (qual(n) && r) begin
            chk("R3 random trigger", c, 1);
            repeat ($urandom % 10) step();
            chk("R5 random busy", busy, 1);
            finish_cal();
            exp_done = 1;
         end else if (qual(n)) begin
            chk("R6 random pending", c, 0);
            chk("R9 random cleared", done, 0);
            repeat ($urandom % 10) step();
            refv = 1; step();
            chk("R6 random release", req, 1);
            finish_cal();
            exp_done = 1;
         end else begin
            chk("R2 random short", c, 0);
            chk("R9 random kept", done, int'(exp_done));
         end
         repeat (3) step();
      end

      summary();
      $finish;
   end
endmodule